// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit settles, for one jump instruction, whether control moves and where the program counter goes next. It takes the current program counter (counted in instructions, not bytes), a 4-bit jump code, a flag that picks the immediate in place of the source register as the right-hand operand, a flag that marks the 32-bit jump class, both 64-bit operands, the 16-bit branch offset and the 32-bit immediate. One clock edge later it presents a taken flag, the next program counter and an illegal flag.

Every compare comes in a 64-bit flavour and a 32-bit flavour. The 32-bit flavour looks only at the low halves of the operands, extended with zeros for unsigned compares and with their own sign bit for signed ones. The unconditional jump reads its displacement from the 16-bit offset in the 64-bit class, and from the 32-bit immediate in the 32-bit class, which gives the long jump its reach. Codes that this unit does not resolve raise the illegal flag and let the program counter step past the instruction.

Top module: `bctu_top`

## Requirements
- R1: Reset is synchronous and active high; while it is asserted, taken_o, illegal_o and next_pc_o read 0 one edge later. All outputs are registered: they reflect the inputs present at the previous rising edge.
- R2: Code 0x0 with cls32_i = 0 is always taken and gives next_pc_o = pc_i + 1 + the sign-extended 16-bit off_i. The operands, imm_i and use_imm_i have no effect on it.
- R3: Code 0x0 with cls32_i = 1 is always taken and gives next_pc_o = pc_i + 1 + the sign-extended 32-bit imm_i; off_i has no effect on it.
- R4: Code 0x1 is taken when the left operand equals the right operand; code 0x5 is taken when they differ.
- R5: Unsigned compares: code 0x2 is taken on left > right, 0x3 on left >= right, 0xa on left < right, 0xb on left <= right.
- R6: Signed (two's complement) compares: code 0x6 is taken on left > right, 0x7 on left >= right, 0xc on left < right, 0xd on left <= right.
- R7: Code 0x4 is taken when the bitwise AND of the left and right operands is non-zero.
- R8: The left operand is dst_i. With use_imm_i = 1 the right operand is imm_i sign-extended to 64 bits and src_i has no effect; with use_imm_i = 0 it is src_i.
- R9: With cls32_i = 1 the compares use only bits 31:0 of both operands, zero-extended for unsigned codes and sign-extended for signed codes; bits 63:32 have no effect.
- R10: A taken conditional branch gives next_pc_o = pc_i + 1 + the sign-extended off_i; a branch not taken gives pc_i + 1. The sum wraps modulo 2^PC_W.
- R11: Codes 0x8, 0x9, 0xe and 0xf set illegal_o = 1 and taken_o = 0 with next_pc_o = pc_i + 1; every other code gives illegal_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | PC_W (32) | Current program counter in instruction units |
| code_i | input | 4 | Jump code |
| use_imm_i | input | 1 | 1: right operand is the sign-extended immediate |
| cls32_i | input | 1 | 1: 32-bit jump class, 0: 64-bit jump class |
| dst_i | input | DATA_W (64) | Left operand |
| src_i | input | DATA_W (64) | Right operand when use_imm_i = 0 |
| off_i | input | OFF_W (16) | Branch offset |
| imm_i | input | IMM_W (32) | Immediate: compare value or long-jump displacement |
| taken_o | output | 1 | Branch taken (registered) |
| next_pc_o | output | PC_W (32) | Next program counter (registered) |
| illegal_o | output | 1 | Code not resolved by this unit (registered) |

## Verification
The bench puts all-ones against one in the operands, so a design that mixes up signed and unsigned compares, or the greater and less codes, sends the branch the wrong way. It loads the high halves with values that contradict the low halves in the 32-bit class; a design that compares all 64 bits there, or extends the low half with the wrong kind of fill, reverses the outcome. The unconditional jump is driven with a large immediate and a small offset in both classes, so a design that reads the wrong field lands thousands of instructions off. The program counter is also driven to its largest value and to zero with negative displacements, which catches an adder that does not wrap or that drops the +1.

// File: rtl/bctu_pkg.sv
package bctu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    JC_ALWAYS = 4'h0,
    JC_EQ     = 4'h1,
    JC_UGT    = 4'h2,
    JC_UGE    = 4'h3,
    JC_ANYSET = 4'h4,
    JC_NE     = 4'h5,
    JC_SGT    = 4'h6,
    JC_SGE    = 4'h7,
    JC_RSV8   = 4'h8,
    JC_RSV9   = 4'h9,
    JC_ULT    = 4'ha,
    JC_ULE    = 4'hb,
    JC_SLT    = 4'hc,
    JC_SLE    = 4'hd,
    JC_RSVE   = 4'he,
    JC_RSVF   = 4'hf
  } jcode_e;

  // Outcome of comparing the two prepared operands.
  typedef struct packed {
    logic eq;
    logic ugt;
    logic ult;
    logic sgt;
    logic slt;
    logic anyset;
  } cmp_flags_t;

endpackage

// File: rtl/bctu_opsel.sv
// Prepares the left and right compare operands: source selection,
// immediate sign extension and the 32-bit class narrowing.
module bctu_opsel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              cls32_i,
  output logic [DATA_W-1:0] lhs_u_o,
  output logic [DATA_W-1:0] rhs_u_o,
  output logic [DATA_W-1:0] lhs_s_o,
  output logic [DATA_W-1:0] rhs_s_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] rhs_full;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_nopad
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign rhs_full = use_imm_i ? imm_ext : src_i;

  always_comb begin
    if (cls32_i) begin
      lhs_u_o = {{HALF_W{1'b0}}, dst_i[HALF_W-1:0]};
      rhs_u_o = {{HALF_W{1'b0}}, rhs_full[HALF_W-1:0]};
      lhs_s_o = {{HALF_W{dst_i[HALF_W-1]}}, dst_i[HALF_W-1:0]};
      rhs_s_o = {{HALF_W{rhs_full[HALF_W-1]}}, rhs_full[HALF_W-1:0]};
    end else begin
      lhs_u_o = dst_i;
      rhs_u_o = rhs_full;
      lhs_s_o = dst_i;
      rhs_s_o = rhs_full;
    end
  end
endmodule

// File: rtl/bctu_cond.sv
// Evaluates the jump code against the prepared operands.
module bctu_cond
  import bctu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] lhs_u_i,
  input  logic [DATA_W-1:0] rhs_u_i,
  input  logic [DATA_W-1:0] lhs_s_i,
  input  logic [DATA_W-1:0] rhs_s_i,
  output logic              take_o,
  output logic              legal_o
);
  cmp_flags_t f;

  always_comb begin
    f.eq     = (lhs_u_i == rhs_u_i);
    f.ugt    = (lhs_u_i >  rhs_u_i);
    f.ult    = (lhs_u_i <  rhs_u_i);
    f.sgt    = ($signed(lhs_s_i) >  $signed(rhs_s_i));
    f.slt    = ($signed(lhs_s_i) <  $signed(rhs_s_i));
    f.anyset = |(lhs_u_i & rhs_u_i);
  end

  always_comb begin
    take_o  = 1'b0;
    legal_o = 1'b1;
    case (jcode_e'(code_i))
      JC_ALWAYS: take_o = 1'b1;
      JC_EQ:     take_o = f.eq;
      JC_NE:     take_o = !f.eq;
      JC_UGT:    take_o = f.ugt;
      JC_UGE:    take_o = f.ugt | f.eq;
      JC_ULT:    take_o = f.ult;
      JC_ULE:    take_o = f.ult | f.eq;
      JC_SGT:    take_o = f.sgt;
      JC_SGE:    take_o = !f.slt;
      JC_SLT:    take_o = f.slt;
      JC_SLE:    take_o = !f.sgt;
      JC_ANYSET: take_o = f.anyset;
      default:   legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bctu_target.sv
// Forms the next program counter from the chosen displacement.
module bctu_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int IMM_W = 32
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             long_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int EXT_W = (PC_W > IMM_W) ? PC_W : IMM_W;

  logic [EXT_W-1:0] off_ext;
  logic [EXT_W-1:0] imm_ext;
  logic [EXT_W-1:0] pc_ext;
  logic [EXT_W-1:0] disp;
  logic [EXT_W-1:0] sum;

  assign off_ext = {{(EXT_W-OFF_W){off_i[OFF_W-1]}}, off_i};

  generate
    if (EXT_W > IMM_W) begin : g_imm_pad
      assign imm_ext = {{(EXT_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_imm_full
      assign imm_ext = imm_i;
    end
    if (EXT_W > PC_W) begin : g_pc_pad
      assign pc_ext = {{(EXT_W-PC_W){1'b0}}, pc_i};
    end else begin : g_pc_full
      assign pc_ext = pc_i;
    end
  endgenerate

  always_comb begin
    if (!take_i)     disp = '0;
    else if (long_i) disp = imm_ext;
    else             disp = off_ext;
    sum = pc_ext + disp + EXT_W'(1);
  end

  assign next_pc_o = sum[PC_W-1:0];
endmodule

// File: rtl/bctu_top.sv
module bctu_top
  import bctu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [3:0]        code_i,
  input  logic              use_imm_i,
  input  logic              cls32_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] lhs_u, rhs_u, lhs_s, rhs_s;
  logic              take_c, legal_c, long_c;
  logic [PC_W-1:0]   next_pc_c;
  logic              seen_q;

  bctu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i),
    .use_imm_i(use_imm_i), .cls32_i(cls32_i),
    .lhs_u_o(lhs_u), .rhs_u_o(rhs_u), .lhs_s_o(lhs_s), .rhs_s_o(rhs_s)
  );

  bctu_cond #(.DATA_W(DATA_W)) u_cond (
    .code_i(code_i), .lhs_u_i(lhs_u), .rhs_u_i(rhs_u),
    .lhs_s_i(lhs_s), .rhs_s_i(rhs_s),
    .take_o(take_c), .legal_o(legal_c)
  );

  // Long displacement only for the unconditional jump of the 32-bit class.
  assign long_c = cls32_i && (code_i == JC_ALWAYS);

  bctu_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_target (
    .pc_i(pc_i), .off_i(off_i), .imm_i(imm_i),
    .long_i(long_c), .take_i(take_c && legal_c),
    .next_pc_o(next_pc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
      next_pc_o <= '0;
      seen_q    <= 1'b0;
    end else begin
      taken_o   <= take_c && legal_c;
      illegal_o <= !legal_c;
      next_pc_o <= next_pc_c;
      seen_q    <= 1'b1;
    end
  end

  // R11: a rejected code never branches.
  p_illegal_no_branch_r11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !taken_o);

  // R10: when nothing is taken the counter steps by exactly one.
  p_fallthrough_step_r10: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_W'(1)));

  // R2/R3: the unconditional code always branches.
  p_always_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(code_i) == 4'h0) |-> taken_o);

  // R4: equal 64-bit register operands take code 0x1.
  p_eq_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(code_i) == 4'h1 && !$past(cls32_i) && !$past(use_imm_i)
     && $past(dst_i) == $past(src_i)) |-> taken_o);

  // R9: 32-bit class equality depends only on the low halves.
  p_eq32_low_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(code_i) == 4'h1 && $past(cls32_i) && !$past(use_imm_i)
     && $past(dst_i[31:0]) == $past(src_i[31:0])) |-> taken_o);
endmodule

// File: tb/bctu_top_test.sv
`timescale 1ns/1ps
module bctu_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc;
  logic [3:0]  code;
  logic        use_imm, cls32;
  logic [63:0] dst, src;
  logic [15:0] off;
  logic [31:0] imm;
  logic        taken, illegal;
  logic [31:0] npc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bctu_top uut (
    .clk(clk), .rst(rst), .pc_i(pc), .code_i(code), .use_imm_i(use_imm),
    .cls32_i(cls32), .dst_i(dst), .src_i(src), .off_i(off), .imm_i(imm),
    .taken_o(taken), .next_pc_o(npc), .illegal_o(illegal)
  );

  task automatic expect_out(input string req, input logic et, input logic [31:0] ep,
                            input logic ei);
    n_run += 3;
    if (taken !== et) begin
      n_fail++; $display("FAIL %s taken: got %b exp %b", req, taken, et);
    end
    if (npc !== ep) begin
      n_fail++; $display("FAIL %s next_pc: got %h exp %h", req, npc, ep);
    end
    if (illegal !== ei) begin
      n_fail++; $display("FAIL %s illegal: got %b exp %b", req, illegal, ei);
    end
  endtask

  // Drive one instruction at the falling edge, sample after the next rising edge.
  task automatic run(input string req, input logic [3:0] c, input logic c32,
                     input logic ui, input logic [63:0] d, input logic [63:0] s,
                     input logic [15:0] o, input logic [31:0] im, input logic [31:0] p,
                     input logic et, input logic [31:0] ep, input logic ei);
    @(negedge clk);
    code = c; cls32 = c32; use_imm = ui; dst = d; src = s; off = o; imm = im; pc = p;
    @(posedge clk); #1;
    expect_out(req, et, ep, ei);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; code = 4'h0; cls32 = 1'b0; use_imm = 1'b0;
    dst = '0; src = '0; off = 16'd7; imm = '0; pc = 32'd40;
    @(posedge clk); #1;
    expect_out("R1", 1'b0, 32'd0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_ja64;
    run("R2", 4'h0, 0, 1, 64'd1, 64'd2, 16'hfffd, 32'd1000, 32'd100, 1, 32'd98, 0);
    run("R2", 4'h0, 0, 0, 64'd0, '1,    16'h7fff, 32'hffff, 32'd0,   1, 32'd32768, 0);
  endtask

  task automatic t_ja32;
    run("R3", 4'h0, 1, 0, 64'd0, 64'd0, 16'd5, 32'h0001_0000, 32'd10, 1, 32'd65547, 0);
    run("R3", 4'h0, 1, 0, 64'd0, 64'd0, 16'd9, -32'sd20,      32'd50, 1, 32'd31, 0);
  endtask

  task automatic t_eq_ne;
    run("R4", 4'h1, 0, 0, 64'h1234, 64'h1234, 16'd4, 0, 32'd0, 1, 32'd5, 0);
    run("R4", 4'h1, 0, 0, 64'h1234, 64'h1235, 16'd4, 0, 32'd0, 0, 32'd1, 0);
    run("R4", 4'h5, 0, 0, 64'd1,    64'd2,    16'd4, 0, 32'd0, 1, 32'd5, 0);
  endtask

  task automatic t_unsigned;
    run("R5", 4'h2, 0, 0, '1,    64'd1, 16'd2, 0, 32'd20, 1, 32'd23, 0);
    run("R5", 4'ha, 0, 0, '1,    64'd1, 16'd2, 0, 32'd20, 0, 32'd21, 0);
    run("R5", 4'h3, 0, 0, 64'd9, 64'd9, 16'd2, 0, 32'd20, 1, 32'd23, 0);
    run("R5", 4'hb, 0, 0, 64'd3, 64'd2, 16'd2, 0, 32'd20, 0, 32'd21, 0);
  endtask

  task automatic t_signed;
    run("R6", 4'h6, 0, 0, '1,      64'd1,  16'd3, 0, 32'd0, 0, 32'd1, 0);
    run("R6", 4'hc, 0, 0, '1,      64'd1,  16'd3, 0, 32'd0, 1, 32'd4, 0);
    run("R6", 4'h7, 0, 0, 64'd6,   64'd6,  16'd3, 0, 32'd0, 1, 32'd4, 0);
    run("R6", 4'hd, 0, 0, -64'sd5, -64'sd5,16'd3, 0, 32'd0, 1, 32'd4, 0);
  endtask

  task automatic t_set;
    run("R7", 4'h4, 0, 0, 64'hf0, 64'h0f, 16'd1, 0, 32'd8, 0, 32'd9, 0);
    run("R7", 4'h4, 0, 0, 64'hf0, 64'h10, 16'd1, 0, 32'd8, 1, 32'd10, 0);
  endtask

  task automatic t_immsel;
    run("R8", 4'h1, 0, 1, '1, 64'd0, 16'd6, 32'hffff_ffff, 32'd0, 1, 32'd7, 0);
    run("R8", 4'h1, 0, 1, '1, '1,    16'd6, 32'd5,         32'd0, 0, 32'd1, 0);
  endtask

  task automatic t_cls32;
    run("R9", 4'h1, 1, 0, 64'haaaa_0000_0000_0007, 64'h5555_0000_0000_0007,
        16'd2, 0, 32'd0, 1, 32'd3, 0);
    run("R9", 4'h6, 1, 0, 64'h0000_0000_8000_0000, 64'd1, 16'd2, 0, 32'd0, 0, 32'd1, 0);
    run("R9", 4'h6, 0, 0, 64'h0000_0000_8000_0000, 64'd1, 16'd2, 0, 32'd0, 1, 32'd3, 0);
    run("R9", 4'h2, 1, 0, 64'h1_0000_0000, 64'd1, 16'd2, 0, 32'd0, 0, 32'd1, 0);
    run("R9", 4'h2, 0, 0, 64'h1_0000_0000, 64'd1, 16'd2, 0, 32'd0, 1, 32'd3, 0);
  endtask

  task automatic t_wrap;
    run("R10", 4'h0, 0, 0, 0, 0, 16'd0,    0, 32'hffff_ffff, 1, 32'd0, 0);
    run("R10", 4'h1, 0, 0, 0, 0, 16'hffff, 0, 32'd0,         1, 32'd0, 0);
    run("R10", 4'h5, 0, 0, 0, 0, 16'd50,   0, 32'hffff_ffff, 0, 32'd0, 0);
  endtask

  task automatic t_illegal;
    run("R11", 4'h8, 0, 0, 0, 0, 16'd9, 32'd9, 32'd30, 0, 32'd31, 1);
    run("R11", 4'h9, 1, 0, 0, 0, 16'd9, 32'd9, 32'd30, 0, 32'd31, 1);
    run("R11", 4'he, 0, 0, 5, 5, 16'd9, 32'd9, 32'd30, 0, 32'd31, 1);
    run("R11", 4'hf, 1, 0, 5, 5, 16'd9, 32'd9, 32'd30, 0, 32'd31, 1);
    run("R11", 4'h1, 0, 0, 5, 5, 16'd9, 32'd9, 32'd30, 1, 32'd40, 0);
  endtask

  initial begin
    rst = 1'b1; pc = '0; code = '0; use_imm = 1'b0; cls32 = 1'b0;
    dst = '0; src = '0; off = '0; imm = '0;
    repeat (2) @(posedge clk);
    t_reset;
    t_ja64;
    t_ja32;
    t_eq_ne;
    t_unsigned;
    t_signed;
    t_set;
    t_immsel;
    t_cls32;
    t_wrap;
    t_illegal;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule